// File: doc/BRIEF.md
# Strap-Latched Frequency Select Controller

This block chooses the frequency configuration that a multi-output clock synthesizer runs with. Several package pins do two jobs. Right after power-on reset they are read once as configuration straps. After that they are handed back to their clock output drivers. The block holds the strap values, shows them inverted as status, and turns them into a six-bit frequency table index.

Register bits that come in on a plain parallel bus can replace the straps in two ways. A software select bit switches the table index from the straps to a software value. A direct mode bit goes further and selects a programmed N/M pair, with Fout = 14.318 MHz × (N+4) / (2×M), in place of the table.

The resolved configuration is made up of the table index or N/M pair, a flag for which of the two is used, and a 3V66 divisor code. It is registered and sent to the synthesizer. A one-cycle change strobe goes with it whenever it differs from the previous value, so that the synthesizer can ramp to the new frequency. The block also registers a run/stop vector with one bit per output, which accounts for the output enables, a global tristate bit and an active-low power-down input.

Top module: `freq_sel_ctrl`

## Requirements
- R1: The straps are captured on the first rising clock edge after `rstN` goes high. `strapOe` is 0 until that edge and 1 from that edge onward.
- R2: The captured straps never change after capture, whatever `strapIn` does. `strapStatusN` is the bitwise inverse of the captured vector, with bit i taken from `strapIn[i]`. `fastSel` equals the captured bit 5.
- R3: When `swSelEn`=0 and `mnMode`=0, `tableIdx` is the captured `strapIn[4:0]` with a 0 as bit 5. In this case `swIndex` has no effect.
- R4: When `swSelEn`=1 and `mnMode`=0, `tableIdx` equals `swIndex`, including 63.
- R5: When `mnMode`=1 and `mVal`≠0, the outputs are `useMn`=1, `nOut`=`nVal`, `mOut`=`mVal` and `tableIdx`=0. In table mode, `useMn`=0, `nOut`=0 and `mOut`=0.
- R6: When `mnMode`=1 and `mVal`=0, the previous configuration is kept unchanged and no strobe is raised.
- R7: `divOut` follows `divCode`. The codes are 00 = CPU/2, 01 = CPU/1.5, 10 = CPU/1 and 11 = CPU/3.
- R8: `changeStb` is high for exactly the cycle after a clock edge that loads a different configuration. The first configuration after capture is always strobed. When the resolved configuration is unchanged, no strobe is raised.
- R9: One edge after capture, `outRun[i]` is `outEnable[i]` registered, provided that `pwrDownN`=1 and `tristateAll`=0.
- R10: When `tristateAll`=1, `outHiZ`=1 and all `outRun` bits are 0 from the next edge onward.
- R11: When `pwrDownN`=0, all `outRun` bits are 0 from the next edge onward. Releasing it restores the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| strapIn | input | 6 | Pin levels: [4:0] hardware index, [5] 24/48 select |
| swSelEn | input | 1 | 1 = software index, 0 = straps |
| swIndex | input | 6 | Software table index |
| mnMode | input | 1 | 1 = use the N/M pair |
| nVal | input | 9 | Programmed N |
| mVal | input | 5 | Programmed M |
| divCode | input | 2 | 3V66 divisor code |
| tristateAll | input | 1 | Tristate all outputs |
| outEnable | input | NUM_OUT | Per-output enable, 1 = active |
| pwrDownN | input | 1 | Active-low power-down |
| strapOe | output | 1 | Pin output drivers enabled |
| strapStatusN | output | 6 | Inverted captured straps |
| fastSel | output | 1 | Captured 24/48 select |
| useMn | output | 1 | Configuration uses the N/M pair |
| tableIdx | output | 6 | Resolved table index |
| nOut | output | 9 | Resolved N |
| mOut | output | 5 | Resolved M |
| divOut | output | 2 | Resolved divisor code |
| changeStb | output | 1 | One-cycle configuration change strobe |
| outRun | output | NUM_OUT | Per-output run (1) / stop (0) |
| outHiZ | output | 1 | Outputs held in tristate |

## Verification
The strap pins are released and then driven to a different pattern. This separates a block that captures once from one that keeps tracking the pins.

The selection is exercised in three ways:
- The unselected source is changed, for example the software index while in strap mode, or the index while in N/M mode. No strobe is expected, which separates a compare on the resolved configuration from a compare on the raw register inputs.
- Each source is switched in turn, and an identical value is rewritten.
- M=0 is written both before and after a valid N/M pair, which shows that the held configuration survives.

The output gating is tried with a mixed enable pattern under tristate and under power-down, which separates per-bit gating from global gating.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int IDX_W   = 6;
  localparam int HW_W    = 5;
  localparam int N_W     = 9;
  localparam int M_W     = 5;
  localparam int DIV_W   = 2;
  localparam int STRAP_W = HW_W + 1;

  typedef struct packed {
    logic             useMn;
    logic [IDX_W-1:0] idx;
    logic [N_W-1:0]   n;
    logic [M_W-1:0]   m;
    logic [DIV_W-1:0] div;
  } cfg_t;

  typedef struct packed {
    logic sampleNow;
    logic running;
    logic loadCfg;
  } ctl_t;

  typedef struct packed {
    logic candValid;
    logic candDiff;
  } dpStat_t;

  typedef enum logic [0:0] {ST_SAMPLE = 1'b0, ST_RUN = 1'b1} phase_e;
endpackage

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
  import fsel_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  output ctl_t    ctl
);
  phase_e phase;
  logic   firstDone;

  always_comb begin
    ctl.sampleNow = (phase == ST_SAMPLE);
    ctl.running   = (phase == ST_RUN);
    ctl.loadCfg   = ctl.running && stat.candValid && (stat.candDiff || !firstDone);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= ST_SAMPLE;
      firstDone <= 1'b0;
    end else begin
      if (ctl.sampleNow) phase <= ST_RUN;
      if (ctl.loadCfg) firstDone <= 1'b1;
    end
  end
endmodule

// File: rtl/fsel_datapath.sv
module fsel_datapath
  import fsel_pkg::*;
#(
  parameter int NUM_OUT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_t               ctl,
  input  logic [STRAP_W-1:0] strapIn,
  input  logic               swSelEn,
  input  logic [IDX_W-1:0]   swIndex,
  input  logic               mnMode,
  input  logic [N_W-1:0]     nVal,
  input  logic [M_W-1:0]     mVal,
  input  logic [DIV_W-1:0]   divCode,
  input  logic               tristateAll,
  input  logic [NUM_OUT-1:0] outEnable,
  input  logic               pwrDownN,
  output dpStat_t            stat,
  output cfg_t               cfg,
  output logic               changeStb,
  output logic               strapOe,
  output logic [STRAP_W-1:0] strapStatusN,
  output logic               fastSel,
  output logic [NUM_OUT-1:0] outRun,
  output logic               outHiZ
);
  logic [STRAP_W-1:0] strapLatch;
  logic [IDX_W-1:0]   hwIdx;
  cfg_t               cand;
  logic               gateOpen;

  // Strap capture: a single load, then frozen.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapLatch <= '0;
      strapOe    <= 1'b0;
    end else if (ctl.sampleNow) begin
      strapLatch <= strapIn;
      strapOe    <= 1'b1;
    end
  end

  assign strapStatusN = ~strapLatch;
  assign fastSel      = strapLatch[STRAP_W-1];

  generate
    if (IDX_W > HW_W) begin : gWiden
      assign hwIdx = {{(IDX_W-HW_W){1'b0}}, strapLatch[HW_W-1:0]};
    end else begin : gTrunc
      assign hwIdx = strapLatch[IDX_W-1:0];
    end
  endgenerate

  // Candidate resolution, normalised so unselected fields read as zero.
  always_comb begin
    cand     = '0;
    cand.div = divCode;
    if (mnMode) begin
      cand.useMn = 1'b1;
      cand.n     = nVal;
      cand.m     = mVal;
    end else begin
      cand.idx = swSelEn ? swIndex : hwIdx;
    end
    stat.candValid = !(mnMode && (mVal == '0));
    stat.candDiff  = (cand != cfg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg       <= '0;
      changeStb <= 1'b0;
    end else begin
      changeStb <= ctl.loadCfg;
      if (ctl.loadCfg) cfg <= cand;
    end
  end

  // Output gating.
  assign gateOpen = ctl.running && pwrDownN && !tristateAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outHiZ <= 1'b0;
    else       outHiZ <= ctl.running && tristateAll;
  end

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : gRun
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) outRun[g] <= 1'b0;
        else       outRun[g] <= gateOpen && outEnable[g];
      end
    end
  endgenerate
endmodule

// File: rtl/freq_sel_ctrl.sv
module freq_sel_ctrl
  import fsel_pkg::*;
#(
  parameter int NUM_OUT = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [5:0]         strapIn,
  input  logic               swSelEn,
  input  logic [5:0]         swIndex,
  input  logic               mnMode,
  input  logic [8:0]         nVal,
  input  logic [4:0]         mVal,
  input  logic [1:0]         divCode,
  input  logic               tristateAll,
  input  logic [NUM_OUT-1:0] outEnable,
  input  logic               pwrDownN,
  output logic               strapOe,
  output logic [5:0]         strapStatusN,
  output logic               fastSel,
  output logic               useMn,
  output logic [5:0]         tableIdx,
  output logic [8:0]         nOut,
  output logic [4:0]         mOut,
  output logic [1:0]         divOut,
  output logic               changeStb,
  output logic [NUM_OUT-1:0] outRun,
  output logic               outHiZ
);
  ctl_t    ctl;
  dpStat_t stat;
  cfg_t    cfg;

  fsel_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .ctl  (ctl)
  );

  fsel_datapath #(.NUM_OUT(NUM_OUT)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .strapIn      (strapIn),
    .swSelEn      (swSelEn),
    .swIndex      (swIndex),
    .mnMode       (mnMode),
    .nVal         (nVal),
    .mVal         (mVal),
    .divCode      (divCode),
    .tristateAll  (tristateAll),
    .outEnable    (outEnable),
    .pwrDownN     (pwrDownN),
    .stat         (stat),
    .cfg          (cfg),
    .changeStb    (changeStb),
    .strapOe      (strapOe),
    .strapStatusN (strapStatusN),
    .fastSel      (fastSel),
    .outRun       (outRun),
    .outHiZ       (outHiZ)
  );

  assign useMn    = cfg.useMn;
  assign tableIdx = cfg.idx;
  assign nOut     = cfg.n;
  assign mOut     = cfg.m;
  assign divOut   = cfg.div;
endmodule

// File: rtl/fsel_checker.sv
module fsel_checker #(
  parameter int NUM_OUT = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [5:0]         strapIn,
  input logic               tristateAll,
  input logic               pwrDownN,
  input logic               strapOe,
  input logic [5:0]         strapStatusN,
  input logic               useMn,
  input logic [5:0]         tableIdx,
  input logic [8:0]         nOut,
  input logic [4:0]         mOut,
  input logic [1:0]         divOut,
  input logic               changeStb,
  input logic [NUM_OUT-1:0] outRun,
  input logic               outHiZ
);
  logic [22:0] cfgBus;
  assign cfgBus = {useMn, tableIdx, nOut, mOut, divOut};

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strapOe) |-> (strapStatusN == ~$past(strapIn)));

  assert_frozen_R2: assert property (@(posedge clk) disable iff (!rstN)
    strapOe |=> $stable(strapStatusN) && strapOe);

  assert_m_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    useMn |-> (mOut != '0));

  assert_change_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strapOe && !$stable(cfgBus)) |-> changeStb);

  assert_hiz_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strapOe && tristateAll) |=> (outHiZ && (outRun == '0)));

  assert_powerdown_R11: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |=> (outRun == '0));

  assert_quiet_before_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strapOe |-> (outRun == '0) && !changeStb);
endmodule

bind freq_sel_ctrl fsel_checker #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .strapIn      (strapIn),
  .tristateAll  (tristateAll),
  .pwrDownN     (pwrDownN),
  .strapOe      (strapOe),
  .strapStatusN (strapStatusN),
  .useMn        (useMn),
  .tableIdx     (tableIdx),
  .nOut         (nOut),
  .mOut         (mOut),
  .divOut       (divOut),
  .changeStb    (changeStb),
  .outRun       (outRun),
  .outHiZ       (outHiZ)
);

// File: tb/sim_freq_sel_ctrl.sv
module sim_freq_sel_ctrl;
  localparam int NOUT = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [5:0]      strapIn = 6'b101101;
  logic            swSelEn = 1'b0;
  logic [5:0]      swIndex = 6'd0;
  logic            mnMode = 1'b0;
  logic [8:0]      nVal = 9'd0;
  logic [4:0]      mVal = 5'd0;
  logic [1:0]      divCode = 2'b00;
  logic            tristateAll = 1'b0;
  logic [NOUT-1:0] outEnable = '1;
  logic            pwrDownN = 1'b1;
  logic            strapOe, fastSel, useMn, changeStb, outHiZ;
  logic [5:0]      strapStatusN, tableIdx;
  logic [8:0]      nOut;
  logic [4:0]      mOut;
  logic [1:0]      divOut;
  logic [NOUT-1:0] outRun;

  int nChecks = 0;
  int nFails  = 0;
  logic [22:0] expQ[$];

  always #4 clk = ~clk;

  freq_sel_ctrl #(.NUM_OUT(NOUT)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Driver side: queue the configuration the requirements predict.
  task automatic expectCfg(input logic um, input logic [5:0] ix, input logic [8:0] n,
                           input logic [4:0] m, input logic [1:0] d);
    expQ.push_back({um, ix, n, m, d});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor: every strobe pops one expected configuration (R8).
  always @(negedge clk) begin
    if (rstN && changeStb) begin
      if (expQ.size() == 0) begin
        chk("R8 unexpected strobe", {9'd0, useMn, tableIdx, nOut, mOut, divOut}, 32'hFFFFFFFF);
      end else begin
        chk("R8 strobed config", {9'd0, useMn, tableIdx, nOut, mOut, divOut},
            {9'd0, expQ.pop_front()});
      end
    end
  end

  initial begin
    #(8 * 5000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", {31'd0, strapOe}, 32'd0);
    chk("R1 run in reset", {16'd0, outRun}, 32'd0);
    // First config: strap index 01101 = 13 (R3).
    expectCfg(1'b0, 6'd13, 9'd0, 5'd0, 2'b00);
    rstN = 1'b1;
    chk("R1 oe before edge", {31'd0, strapOe}, 32'd0);
    tick();
    chk("R1 oe after capture", {31'd0, strapOe}, 32'd1);
    strapIn = 6'b010010;                           // pins now act as outputs
    tick();
    chk("R2 status inverted", {26'd0, strapStatusN}, {26'd0, ~6'b101101});
    chk("R2 fastSel", {31'd0, fastSel}, 32'd1);
    chk("R9 all enabled", {16'd0, outRun}, 32'h0000FFFF);
    chk("R3 strap index", {26'd0, tableIdx}, 32'd13);

    swIndex = 6'd40; tick(); tick();               // R3 swIndex ignored
    chk("R3 idx kept", {26'd0, tableIdx}, 32'd13);

    expectCfg(1'b0, 6'd40, 9'd0, 5'd0, 2'b00);
    swSelEn = 1'b1; tick(); tick();
    chk("R4 sw index", {26'd0, tableIdx}, 32'd40);

    expectCfg(1'b0, 6'd63, 9'd0, 5'd0, 2'b00);
    swIndex = 6'd63; tick(); tick();
    chk("R4 sw index max", {26'd0, tableIdx}, 32'd63);

    expectCfg(1'b0, 6'd63, 9'd0, 5'd0, 2'b11);
    divCode = 2'b11; tick(); tick();
    chk("R7 div CPU/3", {30'd0, divOut}, 32'd3);

    nVal = 9'd200; mnMode = 1'b1; tick(); tick(); // M=0 -> hold (R6)
    chk("R6 hold useMn", {31'd0, useMn}, 32'd0);
    chk("R6 hold idx", {26'd0, tableIdx}, 32'd63);

    expectCfg(1'b1, 6'd0, 9'd511, 5'd31, 2'b11);
    nVal = 9'd511; mVal = 5'd31; tick(); tick();
    chk("R5 N", {23'd0, nOut}, 32'd511);
    chk("R5 M", {27'd0, mOut}, 32'd31);
    chk("R5 idx zero", {26'd0, tableIdx}, 32'd0);

    swIndex = 6'd5; tick(); tick();               // unused in N/M mode, no strobe

    expectCfg(1'b1, 6'd0, 9'd100, 5'd31, 2'b01);
    nVal = 9'd100; divCode = 2'b01; tick(); tick();
    chk("R7 div CPU/1.5", {30'd0, divOut}, 32'd1);

    mVal = 5'd0; tick(); tick();
    chk("R6 keep N", {23'd0, nOut}, 32'd100);
    chk("R6 keep M", {27'd0, mOut}, 32'd31);

    expectCfg(1'b0, 6'd5, 9'd0, 5'd0, 2'b01);
    mnMode = 1'b0; tick(); tick();
    chk("R5 table zero N", {23'd0, nOut}, 32'd0);

    swIndex = 6'd5; divCode = 2'b01; tick(); tick(); // identical rewrite, R8

    outEnable = 16'hA5A5; tick();
    chk("R9 mixed enables", {16'd0, outRun}, 32'h0000A5A5);

    tristateAll = 1'b1; tick();
    chk("R10 hiz", {31'd0, outHiZ}, 32'd1);
    chk("R10 stopped", {16'd0, outRun}, 32'd0);
    tristateAll = 1'b0; tick();
    chk("R10 released", {15'd0, outHiZ, outRun}, 32'h0000A5A5);

    pwrDownN = 1'b0; tick();
    chk("R11 powered down", {16'd0, outRun}, 32'd0);
    pwrDownN = 1'b1; tick();
    chk("R11 restored", {16'd0, outRun}, 32'h0000A5A5);

    chk("R2 status frozen", {26'd0, strapStatusN}, {26'd0, ~6'b101101});
    tick(); tick();
    chk("R8 all strobes seen", expQ.size(), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule